// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel ports, A and B, with two independent data paths: A toward B and B toward A. Each path has one storage cell, and the cell's latch-enable input sets its mode. With latch enable high the cell is transparent, so the far port follows the near port in the same cycle. With latch enable low the cell holds its value, or it loads a new value when its capture clock input rises. Each path has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. No bit is inverted.

The pads sit outside the block. Each side therefore appears as separate vectors: a received value, a per-bit flag that says whether any driver is on the wire, a value to drive and a per-bit drive enable. A drive enable of zero stands for high impedance. The design is synchronous to a system clock, and it samples the capture clock inputs as ordinary data. An asynchronous active-low reset models power-up: it clears the storage cells and turns both drive-enable vectors off. An optional bus keeper replaces any input bit that nothing drives with the last value resolved for that bit.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: With `ab_le` high, `b_out` equals the resolved A value in the same cycle, bit for bit and without inversion.
- R2: When `ab_le` falls, `b_out` keeps the resolved A value sampled at the last system clock edge at which `ab_le` was high.
- R3: With `ab_le` low and `ab_cp` unchanged between system clock edges, `b_out` stays constant whatever A does.
- R4: With `ab_le` low, a low-to-high change of `ab_cp` seen between two system clock edges loads the resolved A value at the second edge. `ab_cp` counts as previously high at reset release, so a high level at release does not load.
- R5: Changes of `ab_cp` while `ab_le` is high leave no effect once `ab_le` falls.
- R6: `b_oe` is all ones exactly when `ab_oe` is 1 and the block is out of reset, and all zeros otherwise. `a_oe` is all ones exactly when `ba_oe_n` is 0 and the block is out of reset, and all zeros otherwise.
- R7: Storage loads and holds in the same way while the matching output enable is inactive.
- R8: The B-to-A path behaves as R1 to R5 describe, using `ba_le`, `ba_cp`, `b_in` and `a_out`.
- R9: While `rst_n` is low both storage cells read zero and both drive-enable vectors are zero. The drive enables stay zero until two system clock edges have passed after `rst_n` rises, and the first load happens at the third edge.
- R10: With `BUS_HOLD`=1, an input bit whose valid flag is 0 resolves to the value that bit resolved to at the previous system clock edge. A bit whose valid flag is 1 resolves to the input bit. The held value starts at zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, models power-up |
| a_in | input | W | Value received on port A |
| a_in_vld | input | W | Per-bit flag: some driver is on A |
| a_out | output | W | Value to drive onto A (B-to-A path) |
| a_oe | output | W | Per-bit drive enable for A |
| b_in | input | W | Value received on port B |
| b_in_vld | input | W | Per-bit flag: some driver is on B |
| b_out | output | W | Value to drive onto B (A-to-B path) |
| b_oe | output | W | Per-bit drive enable for B |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_cp | input | 1 | A-to-B capture clock, rising change loads |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_cp | input | 1 | B-to-A capture clock, rising change loads |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench builds the block with W=18 and BUS_HOLD=1. The full width lets distinct patterns (alternating, walking, all ones, random) show that every bit is independent and none is inverted. Turning the keeper on makes the undriven-input branch reachable, so held values can be observed after the far driver lets go, including for only some of the bits. The variant without the keeper is not built here. Its input path is a plain wire.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_FOLLOW  = 2'd1,
    ST_CAPTURE = 2'd2
  } store_op_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W        = 18,
  parameter bit BUS_HOLD = 1'b1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] vld,
  output logic [W-1:0] res
);
  generate
    if (BUS_HOLD) begin : g_hold
      logic [W-1:0] hold_q;
      logic [W-1:0] hold_d;

      always_comb begin
        for (int i = 0; i < W; i++) begin
          hold_d[i] = vld[i] ? pin[i] : hold_q[i];
        end
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) hold_q <= '0;
        else         hold_q <= hold_d;
      end

      assign res = hold_d;

      AST_KEEPER_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
        (vld == '0) |=> $stable(hold_q)); // R10
    end else begin : g_wire
      logic [W-1:0] vld_unused;
      assign vld_unused = vld;
      assign res = pin;
    end
  endgenerate
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         le,
  input  logic         cp,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic         cp_q;
  logic         cp_rise;
  store_op_e    op;
  logic         st_en;
  logic [W-1:0] st_d;
  logic [W-1:0] st_q;

  // edge detector: previous level reads high out of reset
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cp_q <= 1'b1;
    else         cp_q <= cp;
  end
  assign cp_rise = cp & ~cp_q;

  always_comb begin
    op = ST_HOLD;
    if (le)           op = ST_FOLLOW;
    else if (cp_rise) op = ST_CAPTURE;
    st_en = (op != ST_HOLD);
    st_d  = din;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign dout = le ? din : st_q;

  AST_FOLLOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_ni)
    le |=> (st_q == $past(din))); // R2
  AST_STEADY_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!le && !cp) |=> $stable(st_q)); // R3
  AST_RISE_LOADS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!le && cp && !cp_q) |=> (st_q == $past(din))); // R4
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W        = 18,
  parameter bit BUS_HOLD = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_in_vld,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_in_vld,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_le,
  input  logic         ab_cp,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_cp,
  input  logic         ba_oe_n
);
  localparam int RST_STAGES = 2;

  logic         rst_q_n;
  logic [W-1:0] a_res;
  logic [W-1:0] b_res;
  logic         b_drive;
  logic         a_drive;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  xcvr_keeper #(.W(W), .BUS_HOLD(BUS_HOLD)) u_keep_a (
    .clk(clk), .rst_ni(rst_q_n), .pin(a_in), .vld(a_in_vld), .res(a_res)
  );

  xcvr_keeper #(.W(W), .BUS_HOLD(BUS_HOLD)) u_keep_b (
    .clk(clk), .rst_ni(rst_q_n), .pin(b_in), .vld(b_in_vld), .res(b_res)
  );

  xcvr_store #(.W(W)) u_ab (
    .clk(clk), .rst_ni(rst_q_n), .le(ab_le), .cp(ab_cp), .din(a_res), .dout(b_out)
  );

  xcvr_store #(.W(W)) u_ba (
    .clk(clk), .rst_ni(rst_q_n), .le(ba_le), .cp(ba_cp), .din(b_res), .dout(a_out)
  );

  assign b_drive = ab_oe & rst_q_n;
  assign a_drive = ~ba_oe_n & rst_q_n;
  assign b_oe    = {W{b_drive}};
  assign a_oe    = {W{a_drive}};

  AST_OE_OFF_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> ((a_oe == '0) && (b_oe == '0))); // R9
endmodule

// File: tb/bidir_reg_xcvr_tb.sv
module bidir_reg_xcvr_tb;
  localparam int W = 18;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, a_in_vld, b_in, b_in_vld;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         ab_le, ab_cp, ab_oe, ba_le, ba_cp, ba_oe_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";

  // reference model state
  logic [W-1:0] m_st_ab, m_st_ba, m_hold_a, m_hold_b;
  logic         m_cp_ab, m_cp_ba;
  int           rel_cnt;

  bidir_reg_xcvr #(.W(W), .BUS_HOLD(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_in_vld(b_in_vld), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_cp(ab_cp), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_cp(ba_cp), .ba_oe_n(ba_oe_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] resolve(logic [W-1:0] v, logic [W-1:0] ok, logic [W-1:0] h);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ok[i] ? v[i] : h[i];
    return r;
  endfunction

  task automatic model_reset();
    m_st_ab = '0; m_st_ba = '0; m_hold_a = '0; m_hold_b = '0;
    m_cp_ab = 1'b1; m_cp_ba = 1'b1; rel_cnt = 0;
  endtask

  task automatic model_edge();
    logic [W-1:0] ra, rb;
    if (!rst_n) begin
      model_reset();
    end else begin
      if (rel_cnt >= 2) begin
        ra = resolve(a_in, a_in_vld, m_hold_a);
        rb = resolve(b_in, b_in_vld, m_hold_b);
        if (ab_le) m_st_ab = ra;
        else if (ab_cp && !m_cp_ab) m_st_ab = ra;
        if (ba_le) m_st_ba = rb;
        else if (ba_cp && !m_cp_ba) m_st_ba = rb;
        m_cp_ab = ab_cp; m_cp_ba = ba_cp;
        m_hold_a = ra; m_hold_b = rb;
      end
      if (rel_cnt < 2) rel_cnt++;
    end
  endtask

  task automatic chk(logic [W-1:0] act, logic [W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic active;
    logic [W-1:0] ra, rb;
    active = rst_n && (rel_cnt >= 2);
    ra = resolve(a_in, a_in_vld, m_hold_a);
    rb = resolve(b_in, b_in_vld, m_hold_b);
    chk(b_out, ab_le ? ra : m_st_ab, "b_out");
    chk(a_out, ba_le ? rb : m_st_ba, "a_out");
    chk(b_oe, (active && ab_oe) ? '1 : '0, "b_oe");
    chk(a_oe, (active && !ba_oe_n) ? '1 : '0, "a_oe");
  endtask

  // one clock: model steps with the DUT, then compare away from the edge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    compare_all();
  endtask

  task automatic expect_b(logic [W-1:0] exp, string what);
    chk(b_out, exp, what);
  endtask

  task automatic expect_a(logic [W-1:0] exp, string what);
    chk(a_out, exp, what);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    a_in = '0; b_in = '0; a_in_vld = '1; b_in_vld = '1;
    ab_le = 1'b0; ab_cp = 1'b0; ab_oe = 1'b1;
    ba_le = 1'b0; ba_cp = 1'b0; ba_oe_n = 1'b0;

    // R9: reset state, enables requested but held off
    cur_req = "R9";
    tick(); tick();
    chk(b_oe, '0, "b_oe in reset");
    chk(a_oe, '0, "a_oe in reset");
    expect_b('0, "storage zero in reset");
    a_in = 18'h15555; ab_cp = 1'b1;
    rst_n = 1'b1;
    tick();
    chk(b_oe, '0, "b_oe one edge after release");
    tick();
    chk(b_oe, '1, "b_oe two edges after release");
    // R4: cp high at release is no rising change
    cur_req = "R4";
    tick();
    expect_b('0, "no load from cp high at release");

    // R1: transparent with several patterns
    cur_req = "R1";
    ab_le = 1'b1; ab_cp = 1'b0;
    a_in = 18'h2AAAA; tick(); expect_b(18'h2AAAA, "alternating");
    a_in = 18'h3FFFF; tick(); expect_b(18'h3FFFF, "all ones");
    for (int i = 0; i < W; i += 5) begin
      a_in = 18'h1 << i; tick(); expect_b(18'h1 << i, "walking one");
    end

    // R2: falling latch enable keeps last sampled value
    cur_req = "R2";
    a_in = 18'h0C3A5; tick();
    ab_le = 1'b0; a_in = 18'h33333; tick();
    expect_b(18'h0C3A5, "value before le fell");

    // R3: steady clock at either level holds
    cur_req = "R3";
    a_in = 18'h11111; tick(); expect_b(18'h0C3A5, "cp steady low");
    ab_cp = 1'b1; tick();
    cur_req = "R4";
    expect_b(18'h11111, "rising cp loads");
    cur_req = "R3";
    a_in = 18'h22222; tick(); tick(); expect_b(18'h11111, "cp steady high");

    // R4: another capture
    cur_req = "R4";
    ab_cp = 1'b0; a_in = 18'h0F0F0; tick(); expect_b(18'h11111, "falling cp no load");
    ab_cp = 1'b1; tick(); expect_b(18'h0F0F0, "second rising cp loads");

    // R5: cp toggles while transparent have no extra effect
    cur_req = "R5";
    ab_le = 1'b1; ab_cp = 1'b0; a_in = 18'h01234; tick();
    ab_cp = 1'b1; a_in = 18'h05678; tick();
    ab_cp = 1'b0; a_in = 18'h09ABC; tick();
    ab_le = 1'b0; a_in = 18'h3C3C3; tick();
    expect_b(18'h09ABC, "last transparent sample kept");

    // R6 and R7: disabled outputs, storage still loads
    cur_req = "R6";
    ab_oe = 1'b0; ba_oe_n = 1'b1; tick();
    chk(b_oe, '0, "ab_oe low disables B");
    chk(a_oe, '0, "ba_oe_n high disables A");
    cur_req = "R7";
    ab_cp = 1'b1; a_in = 18'h2468A; tick();
    ab_cp = 1'b0; tick();
    ab_oe = 1'b1; tick();
    expect_b(18'h2468A, "loaded while disabled");
    cur_req = "R6";
    chk(b_oe, '1, "ab_oe high enables B");

    // R8: B-to-A path
    cur_req = "R8";
    ba_oe_n = 1'b0;
    ba_le = 1'b1; b_in = 18'h13579; tick(); expect_a(18'h13579, "transparent");
    ba_le = 1'b0; b_in = 18'h00FFF; tick(); expect_a(18'h13579, "latched on fall");
    ba_cp = 1'b1; tick(); expect_a(18'h00FFF, "rising cp loads");
    b_in = 18'h3F000; tick(); expect_a(18'h00FFF, "cp steady high holds");
    chk(a_oe, '1, "ba_oe_n low enables A");

    // R10: keeper holds undriven bits
    cur_req = "R10";
    ab_le = 1'b1; a_in = 18'h1A5A5; a_in_vld = '1; tick();
    a_in_vld = '0; a_in = 18'h00000; tick();
    expect_b(18'h1A5A5, "all bits released");
    tick(); expect_b(18'h1A5A5, "held across edges");
    a_in_vld = 18'h000FF; a_in = 18'h3FF00; tick();
    expect_b(18'h1A500, "partial drive");
    a_in_vld = '1;

    // mixed traffic, compared every cycle
    cur_req = "R1";
    for (int n = 0; n < 300; n++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      a_in_vld = W'($urandom) | W'($urandom);
      b_in_vld = W'($urandom) | W'($urandom);
      ab_le = ($urandom % 4) == 0; ba_le = ($urandom % 4) == 0;
      ab_cp = $urandom % 2; ba_cp = $urandom % 2;
      ab_oe = $urandom % 2; ba_oe_n = $urandom % 2;
      tick();
    end

    // R9: mid-run reset clears storage
    cur_req = "R9";
    ab_le = 1'b0; ba_le = 1'b0; ab_oe = 1'b1; ba_oe_n = 1'b0;
    a_in_vld = '1; b_in_vld = '1;
    rst_n = 1'b0; #1;
    expect_b('0, "storage cleared by reset");
    expect_a('0, "storage cleared by reset");
    chk(b_oe, '0, "b_oe off at reset");
    tick();
    rst_n = 1'b1; tick(); tick(); tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule